// File: doc/BRIEF.md
# Run-Time Resizable Word Queue

This block is a single-clock first-in first-out queue of 32-bit words, built on 32 physical slots, for the transmit and receive paths of a serial controller. How many of those slots may be used is decided on every cycle from two inputs: a large-queue enable and the width in bits of the serial frame being moved. Narrow frames get a deep queue. Wide frames get a shallower one. With the large-queue enable off, the queue is always four words deep.

A producer writes with `push`/`push_data` and a consumer reads with `pop`. The word taken by a pop appears on `rd_data` after that clock edge and stays there until the next pop or flush. The status outputs (`level`, `empty`, `full`, `full_nxt`, `ovf`) always follow the effective depth in force, so the almost-full and full points move when the frame width changes. A push into a full queue is dropped. In the receive variant, the default, a dropped push also raises a sticky overflow flag that the next pop clears. A pop from an empty queue returns zero and leaves the queue untouched. `flush` empties the queue in one cycle.

Top module: `flex_depth_fifo`

## Requirements
- R1: Effective depth is 4 when `big_en` is 0. When `big_en` is 1 it is 32 for `frame_w` up to 8, 16 for `frame_w` from 9 to 16, and 8 for `frame_w` above 16. `frame_w` is an unsigned 6-bit count.
- R2: Words leave in the order they were accepted. `rd_data` takes the popped word at the clock edge that samples the pop and otherwise holds its value.
- R3: `level` counts the stored words. `empty` is 1 when `level` is 0. `full_nxt` is 1 when `level` equals depth minus 1. `full` is 1 when `level` is at or above the depth.
- R4: A push without a pop while `full` is 1 is dropped and `level` does not change. In the receive variant (`FLAG_DROPS`=1) `ovf` is set at that edge.
- R5: Any pop clears `ovf`. A pop from a full queue releases `full`.
- R6: A pop while `empty` is 1 loads zero into `rd_data` and leaves `level` unchanged.
- R7: A push and a pop in the same cycle on a non-empty queue leave `level` unchanged. The push is accepted even when `full` is 1.
- R8: `flush` takes priority over push and pop. At the next edge `level` is 0, `empty` is 1, and `ovf` and `rd_data` are 0.
- R9: While `rst_n` is low the queue is empty, `level`, `rd_data` and `ovf` are 0, and `full` and `full_nxt` are 0. Reset takes effect without a clock edge. Its release is synchronised, and the block operates from the third rising edge after `rst_n` goes high.
- R10: If the depth shrinks below the stored count, the words are kept, `full` stays 1, and pushes without a pop are dropped until pops bring `level` below the new depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_en | input | 1 | Large-queue enable |
| frame_w | input | 6 | Current serial frame width in bits |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read request |
| flush | input | 1 | Synchronous empty |
| rd_data | output | 32 | Last popped word (zero after an empty pop or flush) |
| level | output | 6 | Number of stored words |
| full | output | 1 | Level at or above effective depth |
| full_nxt | output | 1 | Level equals effective depth minus one |
| empty | output | 1 | No stored words |
| ovf | output | 1 | Sticky dropped-push flag (receive variant) |

## Verification
All state sits one register behind its request. `level`, `rd_data` and `ovf` change at the rising edge that samples push, pop or flush. `full`, `full_nxt` and `empty` are decoded from the count and the depth without a register, so they also react at once to a change of `big_en` or `frame_w`. The bench drives requests at the falling edge and samples a quarter period after the next rising edge, which is after the one register stage and before any further input change. For reset it samples within the same cycle, because assertion acts without a clock.

// File: rtl/flex_fifo_pkg.sv
package flex_fifo_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SLOTS    = 32;
  localparam int unsigned WIDTH_W  = 6;
  localparam int unsigned FIXED_D  = 4;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned MID_W    = 16;

  typedef enum logic [1:0] {
    DEPTH_FIXED  = 2'd0,
    DEPTH_NARROW = 2'd1,
    DEPTH_MID    = 2'd2,
    DEPTH_WIDE   = 2'd3
  } depth_class_e;
endpackage

// File: rtl/ffd_rst_sync.sv
module ffd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ffd_depth_sel.sv
module ffd_depth_sel
  import flex_fifo_pkg::*;
#(
  parameter int unsigned SLOTS_P   = SLOTS,
  parameter int unsigned WIDTH_WP  = WIDTH_W,
  parameter int unsigned FIXED_DP  = FIXED_D,
  parameter int unsigned NARROW_WP = NARROW_W,
  parameter int unsigned MID_WP    = MID_W,
  localparam int unsigned CNT_W    = $clog2(SLOTS_P) + 1
) (
  input  logic                big_en,
  input  logic [WIDTH_WP-1:0] frame_w,
  output logic [CNT_W-1:0]    depth
);
  depth_class_e cls;

  always_comb begin
    if (!big_en)                           cls = DEPTH_FIXED;
    else if (frame_w <= WIDTH_WP'(NARROW_WP)) cls = DEPTH_NARROW;
    else if (frame_w <= WIDTH_WP'(MID_WP))    cls = DEPTH_MID;
    else                                   cls = DEPTH_WIDE;
  end

  always_comb begin
    unique case (cls)
      DEPTH_NARROW: depth = CNT_W'(SLOTS_P);
      DEPTH_MID:    depth = CNT_W'(SLOTS_P / 2);
      DEPTH_WIDE:   depth = CNT_W'(SLOTS_P / 4);
      default:      depth = CNT_W'(FIXED_DP);
    endcase
  end
endmodule

// File: rtl/ffd_ctrl.sv
module ffd_ctrl #(
  parameter int unsigned SLOTS_P    = 32,
  parameter bit          FLAG_DROPS = 1'b1,
  localparam int unsigned PTR_W     = $clog2(SLOTS_P),
  localparam int unsigned CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [CNT_W-1:0] depth,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_take,
  output logic             rd_zero,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             full_nxt,
  output logic             empty,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [PTR_W-1:0] P_ONE = PTR_W'(1);

  logic [PTR_W-1:0] wr_ptr_n, rd_ptr_n;
  logic [CNT_W-1:0] level_n;
  logic             pop_ok, push_ok, drop;
  logic             cnt_en;

  assign empty    = (level == '0);
  assign full     = (level >= depth);
  assign full_nxt = (level == depth - C_ONE);

  assign pop_ok   = pop && !empty && !flush;
  assign push_ok  = push && !flush && (!full || pop_ok);
  assign drop     = push && !flush && !push_ok;
  assign wr_en    = push_ok;
  assign rd_take  = pop_ok;
  assign rd_zero  = pop && empty && !flush;
  assign cnt_en   = flush || push_ok || pop_ok;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    level_n  = level;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      level_n  = '0;
    end else begin
      if (push_ok) wr_ptr_n = wr_ptr + P_ONE;
      if (pop_ok)  rd_ptr_n = rd_ptr + P_ONE;
      if (push_ok && !pop_ok)      level_n = level + C_ONE;
      else if (pop_ok && !push_ok) level_n = level - C_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (cnt_en) begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= level_n;
    end
  end

  generate
    if (FLAG_DROPS) begin : g_flag
      logic ovf_q, ovf_n, ovf_en;
      assign ovf_en = flush || drop || pop;
      always_comb begin
        if (flush)     ovf_n = 1'b0;
        else if (drop) ovf_n = 1'b1;
        else           ovf_n = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn)     ovf_q <= 1'b0;
        else if (ovf_en) ovf_q <= ovf_n;
      end
      assign ovf = ovf_q;
    end else begin : g_silent
      assign ovf = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ffd_store.sv
module ffd_store #(
  parameter int unsigned SLOTS_P = 32,
  parameter int unsigned WORD_WP = 32,
  localparam int unsigned PTR_W  = $clog2(SLOTS_P)
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic [WORD_WP-1:0] wr_data,
  input  logic [PTR_W-1:0]   rd_ptr,
  input  logic               rd_take,
  input  logic               rd_zero,
  input  logic               flush,
  output logic [WORD_WP-1:0] rd_data
);
  logic [WORD_WP-1:0] mem [SLOTS_P];
  logic [WORD_WP-1:0] rd_q, rd_n;
  logic               rd_en;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_en = flush || rd_take || rd_zero;

  always_comb begin
    if (rd_take && !flush) rd_n = mem[rd_ptr];
    else                   rd_n = '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    rd_q <= '0;
    else if (rd_en) rd_q <= rd_n;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/flex_depth_fifo.sv
module flex_depth_fifo
  import flex_fifo_pkg::*;
#(
  parameter int unsigned WORD_WP    = WORD_W,
  parameter int unsigned SLOTS_P    = SLOTS,
  parameter int unsigned WIDTH_WP   = WIDTH_W,
  parameter int unsigned FIXED_DP   = FIXED_D,
  parameter int unsigned NARROW_WP  = NARROW_W,
  parameter int unsigned MID_WP     = MID_W,
  parameter bit          FLAG_DROPS = 1'b1,
  localparam int unsigned PTR_W     = $clog2(SLOTS_P),
  localparam int unsigned CNT_W     = PTR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                big_en,
  input  logic [WIDTH_WP-1:0] frame_w,
  input  logic                push,
  input  logic [WORD_WP-1:0]  push_data,
  input  logic                pop,
  input  logic                flush,
  output logic [WORD_WP-1:0]  rd_data,
  output logic [CNT_W-1:0]    level,
  output logic                full,
  output logic                full_nxt,
  output logic                empty,
  output logic                ovf
);
  logic             rst_sn;
  logic [CNT_W-1:0] depth;
  logic             wr_en, rd_take, rd_zero;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  ffd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ffd_depth_sel #(
    .SLOTS_P   (SLOTS_P),
    .WIDTH_WP  (WIDTH_WP),
    .FIXED_DP  (FIXED_DP),
    .NARROW_WP (NARROW_WP),
    .MID_WP    (MID_WP)
  ) u_depth (
    .big_en  (big_en),
    .frame_w (frame_w),
    .depth   (depth)
  );

  ffd_ctrl #(
    .SLOTS_P    (SLOTS_P),
    .FLAG_DROPS (FLAG_DROPS)
  ) u_ctrl (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .push     (push),
    .pop      (pop),
    .flush    (flush),
    .depth    (depth),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .rd_take  (rd_take),
    .rd_zero  (rd_zero),
    .level    (level),
    .full     (full),
    .full_nxt (full_nxt),
    .empty    (empty),
    .ovf      (ovf)
  );

  ffd_store #(
    .SLOTS_P (SLOTS_P),
    .WORD_WP (WORD_WP)
  ) u_store (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (push_data),
    .rd_ptr  (rd_ptr),
    .rd_take (rd_take),
    .rd_zero (rd_zero),
    .flush   (flush),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/flex_depth_fifo_chk.sv
module flex_depth_fifo_chk #(
  parameter int unsigned WORD_WP  = 32,
  parameter int unsigned WIDTH_WP = 6,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned SLOTS_P  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                big_en,
  input logic [WIDTH_WP-1:0] frame_w,
  input logic                push,
  input logic [WORD_WP-1:0]  push_data,
  input logic                pop,
  input logic                flush,
  input logic [WORD_WP-1:0]  rd_data,
  input logic [CNT_W-1:0]    level,
  input logic                full,
  input logic                full_nxt,
  input logic                empty,
  input logic                ovf
);
  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(SLOTS_P));
  // R4
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level)) && ovf);
  // R6
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (rd_data == '0) && empty);
  // R7
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !flush) |=> (level == $past(level)));
  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !ovf && (rd_data == '0));
  // R5
  pop_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |=> !ovf);
endmodule

bind flex_depth_fifo flex_depth_fifo_chk #(
  .WORD_WP  (WORD_WP),
  .WIDTH_WP (WIDTH_WP),
  .CNT_W    (CNT_W),
  .SLOTS_P  (SLOTS_P)
) u_chk (.*);

// File: tb/tb_flex_depth_fifo.sv
module tb_flex_depth_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        big_en, push, pop, flush;
  logic [5:0]  frame_w;
  logic [31:0] push_data, rd_data;
  logic [5:0]  level;
  logic        full, full_nxt, empty, ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flex_depth_fifo dut (
    .clk(clk), .rst_n(rst_n), .big_en(big_en), .frame_w(frame_w),
    .push(push), .push_data(push_data), .pop(pop), .flush(flush),
    .rd_data(rd_data), .level(level), .full(full), .full_nxt(full_nxt),
    .empty(empty), .ovf(ovf)
  );

  // fields: big[35] fw[34:29] push[28] pop[27] flush[26] dat[25:18]
  //         lvl[17:12] full[11] fnxt[10] empty[9] ovf[8] rd[7:0]
  localparam logic [35:0] VEC [12] = '{
    {1'b0, 6'd4,  3'b100, 8'hA1, 6'd1, 4'b0000, 8'h00},
    {1'b0, 6'd4,  3'b100, 8'hA2, 6'd2, 4'b0000, 8'h00},
    {1'b0, 6'd4,  3'b100, 8'hA3, 6'd3, 4'b0100, 8'h00},
    {1'b0, 6'd4,  3'b100, 8'hA4, 6'd4, 4'b1000, 8'h00},
    {1'b0, 6'd4,  3'b100, 8'hA5, 6'd4, 4'b1001, 8'h00},
    {1'b0, 6'd4,  3'b010, 8'h00, 6'd3, 4'b0100, 8'hA1},
    {1'b0, 6'd4,  3'b110, 8'hB1, 6'd3, 4'b0100, 8'hA2},
    {1'b0, 6'd4,  3'b001, 8'h00, 6'd0, 4'b0010, 8'h00},
    {1'b0, 6'd4,  3'b010, 8'h00, 6'd0, 4'b0010, 8'h00},
    {1'b1, 6'd20, 3'b100, 8'hC1, 6'd1, 4'b0000, 8'h00},
    {1'b1, 6'd12, 3'b100, 8'hC2, 6'd2, 4'b0000, 8'h00},
    {1'b1, 6'd12, 3'b111, 8'hC3, 6'd0, 4'b0010, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic b, input logic [5:0] fw, input logic pu,
                      input logic po, input logic fl, input logic [31:0] d);
    @(negedge clk);
    big_en = b; frame_w = fw; push = pu; pop = po; flush = fl; push_data = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; big_en = 1'b0; frame_w = 6'd4;
    push = 1'b0; pop = 1'b0; flush = 1'b0; push_data = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R9 reset state
    chk("R9 level", 32'(level), 32'd0);
    chk("R9 empty", 32'(empty), 32'd1);
    chk("R9 full/fnxt/ovf", {29'd0, full, full_nxt, ovf}, 32'd0);
    chk("R9 rd_data", rd_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      step(VEC[i][35], VEC[i][34:29], VEC[i][28], VEC[i][27], VEC[i][26],
           {24'd0, VEC[i][25:18]});
      chk($sformatf("R3 vec%0d level", i), 32'(level), 32'(VEC[i][17:12]));
      chk($sformatf("R3 vec%0d flags", i), {28'd0, full, full_nxt, empty, ovf},
          {28'd0, VEC[i][11:8]});
      chk($sformatf("R2 vec%0d rd_data", i), rd_data, {24'd0, VEC[i][7:0]});
    end

    // R1 depth 32 for frame width 8: fill and check the flags
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 6'd8, 1'b1, 1'b0, 1'b0, 32'h100 + 32'(i));
      chk("R3 fill32 level", 32'(level), 32'(i + 1));
      chk("R1 fill32 full_nxt", 32'(full_nxt), 32'(i == 30));
      chk("R1 fill32 full", 32'(full), 32'(i == 31));
    end
    step(1'b1, 6'd8, 1'b1, 1'b0, 1'b0, 32'hDEAD);
    chk("R4 drop level", 32'(level), 32'd32);
    chk("R4 drop ovf", 32'(ovf), 32'd1);
    // R7 push with pop while full is accepted
    step(1'b1, 6'd8, 1'b1, 1'b1, 1'b0, 32'h200);
    chk("R7 level kept", 32'(level), 32'd32);
    chk("R5 ovf cleared", 32'(ovf), 32'd0);
    chk("R2 first out", rd_data, 32'h100);
    for (int i = 1; i < 32; i++) begin
      step(1'b1, 6'd8, 1'b0, 1'b1, 1'b0, 32'h0);
      chk("R2 drain order", rd_data, 32'h100 + 32'(i));
      if (i == 1) chk("R5 full released", 32'(full), 32'd0);
    end
    step(1'b1, 6'd8, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R7 pushed word out", rd_data, 32'h200);
    chk("R3 empty after drain", 32'(empty), 32'd1);
    step(1'b1, 6'd8, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R6 empty pop zero", rd_data, 32'd0);
    chk("R6 empty pop level", 32'(level), 32'd0);

    // R1 depth 8 for frame width 32
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 6'd32, 1'b1, 1'b0, 1'b0, 32'h300 + 32'(i));
      chk("R1 d8 full_nxt", 32'(full_nxt), 32'(i == 6));
      chk("R1 d8 full", 32'(full), 32'(i == 7));
    end
    // R10 shrink to the fixed depth of 4 with 8 stored
    step(1'b0, 6'd32, 1'b1, 1'b0, 1'b0, 32'h3FF);
    chk("R10 shrink level", 32'(level), 32'd8);
    chk("R10 shrink full", 32'(full), 32'd1);
    chk("R10 shrink drop ovf", 32'(ovf), 32'd1);
    for (int i = 0; i < 5; i++) step(1'b0, 6'd32, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R10 level after pops", 32'(level), 32'd3);
    chk("R10 full released", 32'(full), 32'd0);
    chk("R10 full_nxt at 3", 32'(full_nxt), 32'd1);
    chk("R10 words kept", rd_data, 32'h304);

    // R1 boundary: width 16 gives depth 16
    step(1'b1, 6'd16, 1'b0, 1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 15; i++) step(1'b1, 6'd16, 1'b1, 1'b0, 1'b0, 32'h400);
    chk("R1 w16 full_nxt", 32'(full_nxt), 32'd1);
    chk("R1 w16 full", 32'(full), 32'd0);
    // R1 boundary: width 17 gives depth 8
    @(negedge clk); frame_w = 6'd17; push = 1'b0; #1;
    chk("R1 w17 full", 32'(full), 32'd1);

    // R9 asynchronous reset mid-run
    @(negedge clk); #(CLK_PERIOD/8); rst_n = 1'b0; #1;
    chk("R9 async level", 32'(level), 32'd0);
    chk("R9 async empty", 32'(empty), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    step(1'b0, 6'd4, 1'b1, 1'b0, 1'b0, 32'h55);
    chk("R9 runs after release", 32'(level), 32'd1);

    finish_run();
  end
endmodule